// File: doc/BRIEF.md
# Gate Driver Supply Fault Supervisor

This block supervises the supplies of a three-phase MOSFET gate driver. It holds one 8-bit control register, written through a synchronous write port and always readable. From that register it exports two static selects: one chooses complementary or direct gate drive, and one sets the undervoltage comparator threshold.

Two asynchronous comparator inputs enter the block. One reports gate-supply undervoltage, covering the gate supply and the charge pump together. The other reports drain-high supply overvoltage. The undervoltage input is blanked over a programmable time. Only an undervoltage condition that lasts the whole window raises the fault flag. A shorter pulse is discarded, and the next pulse is timed again from zero.

A two-state mode machine moves between Standby and Normal. Reset puts it in Standby. A host wake request moves it to Normal. Overvoltage returns it to Standby, and requests regulator shutdown, but only when shutdown on overvoltage is enabled.

Top module: `gdrv_supply_supervisor`

## Requirements
- R1: The control register resets to 0x78. A write with `cfg_we` high loads `cfg_wdata` at the clock edge, and `cfg_rdata` shows the register contents. Field layout: bit 7 is the complementary-drive select, bit 6 is overvoltage shutdown enable, bit 5 is undervoltage monitor enable, bit 4 is the threshold select, and bits 3:0 are the blanking code.
- R2: `comp_drive` follows register bit 7 (1 = complementary, 0 = direct from six individual gate inputs). `uv_lvl_hi` follows register bit 4 (1 = high threshold, 0 = low threshold).
- R3: Both comparator inputs pass through a two-flop synchronizer. After the undervoltage input goes high and stays high, `uv_flag` rises exactly 2 + (code+1) × CLKS_PER_UNIT clock edges later. CLKS_PER_UNIT is the number of clocks in one 770 ns unit. This holds at codes 0x0 and 0xF as well.
- R4: An undervoltage pulse shorter than the blanking window raises no flag. The next pulse is timed from zero.
- R5: `uv_flag` stays high while the comparator stays high. It falls on the third clock edge after the comparator goes low.
- R6: With bit 5 clear, `uv_flag` is never raised. Clearing bit 5 while the flag is set drops the flag at the next clock edge.
- R7: After reset, the mode is Standby (`mode_normal` = 0) and `reg_shdn_req` is 0.
- R8: In Standby, `wake_req` high at a clock edge moves the mode to Normal at that edge, provided the synchronized overvoltage input is low. While overvoltage is present, a wake request is ignored. A successful wake clears `reg_shdn_req`.
- R9: In Normal with bit 6 set, synchronized overvoltage moves the mode to Standby and sets `reg_shdn_req` at the next edge. This is three edges after the raw input rises.
- R10: In Normal with bit 6 clear, overvoltage leaves the mode in Normal and leaves `reg_shdn_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| uv_cmp | input | 1 | Asynchronous gate-supply undervoltage comparator |
| ov_cmp | input | 1 | Asynchronous drain-supply overvoltage comparator |
| wake_req | input | 1 | Synchronous host request to enter Normal |
| uv_flag | output | 1 | Filtered undervoltage fault |
| reg_shdn_req | output | 1 | Gate and charge-pump regulator shutdown request after overvoltage |
| mode_normal | output | 1 | 1 = Normal, 0 = Standby |
| comp_drive | output | 1 | Complementary (1) or direct (0) gate drive select |
| uv_lvl_hi | output | 1 | Undervoltage threshold select, 1 = high |

## Verification
Sustained undervoltage is applied at the shortest, the reset-default and the longest blanking codes. Landing on the exact edge of each flag rise separates a correct window from one that is off by a unit or by one clock.

A pulse one filter clock short of the window, followed by a full-length pulse, shows that the timer restarts from zero rather than resuming. Sustained undervoltage with monitoring disabled, and disabling while the flag is set, show that the enable gates both raising and holding the flag.

Overvoltage is applied with shutdown disabled and with it enabled. A wake request is issued both during overvoltage and after it clears. Together these separate the shutdown policy from the wake gating.

// File: rtl/gdrv_sup_pkg.sv
// Package: shared types and control-register layout for the gate driver
// supply supervisor. Assumes an 8-bit control register.
package gdrv_sup_pkg;
    localparam int CFG_W        = 8;
    localparam int CODE_W       = 4;
    localparam int BIT_COMP     = 7;
    localparam int BIT_OVSD     = 6;
    localparam int BIT_UVEN     = 5;
    localparam int BIT_LVL      = 4;
    localparam logic [CFG_W-1:0] CFG_RESET = 8'h78;

    typedef enum logic {
        MODE_STANDBY = 1'b0,
        MODE_NORMAL  = 1'b1
    } gdrv_mode_e;
endpackage

// File: rtl/gdrv_sync.sv
// Module: two-flop synchronizer for W independent asynchronous bits.
// Assumes each bit is a level that stays stable for several clocks.
module gdrv_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Capture the asynchronous inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/gdrv_cfg_reg.sv
// Module: 8-bit control register with a synchronous write port and a
// fixed reset value. Assumes the writer holds cfg_we for one clock per write.
module gdrv_cfg_reg
    import gdrv_sup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q
);
    // Load write data or hold; reset to the documented default.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= CFG_RESET;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/gdrv_uv_filter.sv
// Module: undervoltage blanking filter. The flag is raised once the
// synchronized comparator has been high for (code+1)*CLKS_PER_UNIT
// consecutive clocks. It holds while the input stays high and clears when
// the input falls or monitoring is disabled. Assumes uv_s is synchronized.
module gdrv_uv_filter #(
    parameter int CLKS_PER_UNIT = 154,
    parameter int CODE_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic              uv_s,
    output logic              flag
);
    localparam int MAX_UNITS = 1 << CODE_W;
    localparam int CNT_W     = $clog2(MAX_UNITS * CLKS_PER_UNIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Window length in clocks for the programmed code.
    always_comb begin
        limit = (CNT_W'(code) + CNT_W'(1)) * CNT_W'(CLKS_PER_UNIT);
    end

    // Count consecutive high clocks; restart on any low or on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            flag  <= 1'b0;
        end else if (!en || !uv_s) begin
            cnt_q <= '0;
            flag  <= 1'b0;
        end else if (!flag) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == limit - CNT_W'(1)) flag <= 1'b1;
        end
    end
endmodule

// File: rtl/gdrv_mode_fsm.sv
// Module: Standby/Normal mode machine. Reset enters Standby. A wake request
// enters Normal when no overvoltage is present. Overvoltage with shutdown
// enabled returns to Standby and latches a regulator shutdown request until
// the next wake. Assumes ov_s is synchronized.
module gdrv_mode_fsm
    import gdrv_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ov_s,
    input  logic       ovsd_en,
    input  logic       wake_req,
    output gdrv_mode_e mode,
    output logic       shdn_req
);
    // Mode transitions and shutdown request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_STANDBY;
            shdn_req <= 1'b0;
        end else begin
            unique case (mode)
                MODE_STANDBY: begin
                    if (wake_req && !ov_s) begin
                        mode     <= MODE_NORMAL;
                        shdn_req <= 1'b0;
                    end
                end
                MODE_NORMAL: begin
                    if (ov_s && ovsd_en) begin
                        mode     <= MODE_STANDBY;
                        shdn_req <= 1'b1;
                    end
                end
                default: mode <= MODE_STANDBY;
            endcase
        end
    end
endmodule

// File: rtl/gdrv_supply_supervisor.sv
// Module: top of the gate driver supply supervisor. It ties together the
// control register, the comparator synchronizers, the undervoltage blanking
// filter and the mode machine. Assumes CLKS_PER_UNIT clocks make one 770 ns
// unit (154 at 200 MHz).
module gdrv_supply_supervisor
    import gdrv_sup_pkg::*;
#(
    parameter int CLKS_PER_UNIT = 154
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             uv_cmp,
    input  logic             ov_cmp,
    input  logic             wake_req,
    output logic             uv_flag,
    output logic             reg_shdn_req,
    output logic             mode_normal,
    output logic             comp_drive,
    output logic             uv_lvl_hi
);
    logic [CFG_W-1:0] cfg_q;
    logic [1:0]       cmp_s;
    logic             uv_sync;
    logic             ov_sync;
    gdrv_mode_e       mode;

    gdrv_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    gdrv_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ov_cmp, uv_cmp}),
        .q_sync  (cmp_s)
    );

    // Split the synchronized comparator pair.
    always_comb begin
        uv_sync = cmp_s[0];
        ov_sync = cmp_s[1];
    end

    gdrv_uv_filter #(
        .CLKS_PER_UNIT (CLKS_PER_UNIT),
        .CODE_W        (CODE_W)
    ) u_uvf (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_q[BIT_UVEN]),
        .code  (cfg_q[CODE_W-1:0]),
        .uv_s  (uv_sync),
        .flag  (uv_flag)
    );

    gdrv_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ov_s     (ov_sync),
        .ovsd_en  (cfg_q[BIT_OVSD]),
        .wake_req (wake_req),
        .mode     (mode),
        .shdn_req (reg_shdn_req)
    );

    // Export register contents, static selects and the current mode.
    always_comb begin
        cfg_rdata   = cfg_q;
        comp_drive  = cfg_q[BIT_COMP];
        uv_lvl_hi   = cfg_q[BIT_LVL];
        mode_normal = (mode == MODE_NORMAL);
    end
endmodule

// File: rtl/gdrv_sup_checker.sv
// Module: property checker for the supply supervisor, attached by bind.
module gdrv_sup_checker (
    input logic clk,
    input logic rst_n,
    input logic uv_s,
    input logic ov_s,
    input logic uv_en,
    input logic ovsd_en,
    input logic wake_req,
    input logic uv_flag,
    input logic mode_normal,
    input logic shdn_req
);
    // R3
    uv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_flag) |-> (uv_s && uv_en));
    // R5
    uv_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_s |=> !uv_flag);
    // R6
    uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_en |=> !uv_flag);
    // R8
    wake_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_normal && wake_req && !ov_s) |=> (mode_normal && !shdn_req));
    // R8
    wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_normal && ov_s) |=> !mode_normal);
    // R9
    ov_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_normal && ov_s && ovsd_en) |=> (!mode_normal && shdn_req));
    // R10
    ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_normal && !ovsd_en) |=> (mode_normal && $stable(shdn_req)));
endmodule

bind gdrv_supply_supervisor gdrv_sup_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_s        (uv_sync),
    .ov_s        (ov_sync),
    .uv_en       (cfg_rdata[5]),
    .ovsd_en     (cfg_rdata[6]),
    .wake_req    (wake_req),
    .uv_flag     (uv_flag),
    .mode_normal (mode_normal),
    .shdn_req    (reg_shdn_req)
);

// File: tb/tb_gdrv_supply_supervisor.sv
module tb_gdrv_supply_supervisor;
    localparam int U = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       uv_cmp = 1'b0;
    logic       ov_cmp = 1'b0;
    logic       wake_req = 1'b0;
    logic       uv_flag, reg_shdn_req, mode_normal, comp_drive, uv_lvl_hi;

    always #2.5 clk = ~clk;

    gdrv_supply_supervisor #(.CLKS_PER_UNIT(U)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .uv_cmp(uv_cmp), .ov_cmp(ov_cmp),
        .wake_req(wake_req), .uv_flag(uv_flag), .reg_shdn_req(reg_shdn_req),
        .mode_normal(mode_normal), .comp_drive(comp_drive), .uv_lvl_hi(uv_lvl_hi)
    );

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;
    int   applied = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return cfg_rdata;
            1: return {7'd0, uv_flag};
            2: return {7'd0, reg_shdn_req};
            3: return {7'd0, mode_normal};
            4: return {7'd0, comp_drive};
            default: return {7'd0, uv_lvl_hi};
        endcase
    endfunction

    task automatic expect_now(int sel, logic [7:0] e, string req);
        exp_t it;
        it.sel = sel; it.exp = e; it.req = req;
        exp_q.push_back(it);
        -> chk_ev;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) begin
            exp_t it = exp_q.pop_front();
            logic [7:0] act = observe(it.sel);
            applied++;
            if (act !== it.exp) begin
                miscompares++;
                $display("FAIL %s sel=%0d actual=%h expected=%h t=%0t",
                         it.req, it.sel, act, it.exp, $time);
            end
        end
    endtask

    // Monitor: pops expected items and compares against the outputs.
    initial forever begin
        @(chk_ev);
        drain();
    end

    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic uv_window(int code, string req);
        int lim = (code + 1) * U;
        uv_cmp = 1'b1;
        edges(1 + lim);
        expect_now(1, 8'd0, req);
        edges(1);
        expect_now(1, 8'd1, req);
    endtask

    task automatic uv_release(string req);
        uv_cmp = 1'b0;
        edges(2);
        expect_now(1, 8'd1, req);
        edges(1);
        expect_now(1, 8'd0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        // R1 R2 R7 reset state
        expect_now(0, 8'h78, "R1");
        expect_now(1, 8'd0, "R7");
        expect_now(2, 8'd0, "R7");
        expect_now(3, 8'd0, "R7");
        expect_now(4, 8'd0, "R2");
        expect_now(5, 8'd1, "R2");

        // R3 at reset-default code 8
        uv_window(8, "R3");
        uv_release("R5");

        write_cfg(8'h25);
        expect_now(0, 8'h25, "R1");
        expect_now(5, 8'd0, "R2");
        uv_window(5, "R3");
        edges(10);
        expect_now(1, 8'd1, "R5");
        uv_release("R5");

        // R4 short pulse, then full window restarts from zero
        uv_cmp = 1'b1;
        edges(6 * U - 1);
        uv_cmp = 1'b0;
        expect_now(1, 8'd0, "R4");
        edges(4);
        expect_now(1, 8'd0, "R4");
        uv_window(5, "R4");
        uv_release("R4");

        // R3 boundary codes
        write_cfg(8'h20);
        uv_window(0, "R3");
        uv_release("R3");
        write_cfg(8'h2F);
        uv_window(15, "R3");
        uv_release("R3");

        // R6 monitor disabled
        write_cfg(8'h0F);
        uv_cmp = 1'b1;
        edges(60);
        expect_now(1, 8'd0, "R6");
        write_cfg(8'h25);
        edges(6 * U + 2);
        expect_now(1, 8'd1, "R6");
        write_cfg(8'h05);
        expect_now(1, 8'd1, "R6");
        edges(1);
        expect_now(1, 8'd0, "R6");
        uv_cmp = 1'b0;
        edges(3);

        // R8 wake into Normal
        write_cfg(8'h25);
        wake_req = 1'b1;
        edges(1);
        wake_req = 1'b0;
        expect_now(3, 8'd1, "R8");
        expect_now(2, 8'd0, "R8");

        // R10 overvoltage without shutdown enable
        ov_cmp = 1'b1;
        edges(6);
        expect_now(3, 8'd1, "R10");
        expect_now(2, 8'd0, "R10");
        ov_cmp = 1'b0;
        edges(3);

        // R9 overvoltage with shutdown enable
        write_cfg(8'h65);
        ov_cmp = 1'b1;
        edges(2);
        expect_now(3, 8'd1, "R9");
        edges(1);
        expect_now(3, 8'd0, "R9");
        expect_now(2, 8'd1, "R9");

        // R8 wake ignored while overvoltage present
        wake_req = 1'b1;
        edges(1);
        wake_req = 1'b0;
        expect_now(3, 8'd0, "R8");
        expect_now(2, 8'd1, "R8");
        ov_cmp = 1'b0;
        edges(3);
        wake_req = 1'b1;
        edges(1);
        wake_req = 1'b0;
        expect_now(3, 8'd1, "R8");
        expect_now(2, 8'd0, "R8");

        // R2 complementary select and high threshold
        write_cfg(8'h95);
        expect_now(4, 8'd1, "R2");
        expect_now(5, 8'd1, "R2");
        expect_now(0, 8'h95, "R1");

        edges(2);
        drain();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule